// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a watchdog controlled over a simple register port. It holds a 32-bit down-counter. Software unlocks the register file, programs a reload value and turns the counter on. After that, software must service the timer by writing the clear register often enough. Each service write drops any pending interrupt and restarts the count from the reload value.

If the count runs out once, the block raises an interrupt and starts the count again. If it runs out a second time while that interrupt is still pending, and the reset path is enabled, the block asserts a system reset request. That request stays asserted until the block itself is reset.

Every write except one to the lock register is dropped until a magic key has been written to the lock register. Reads are always allowed. The register port is a plain select/enable/write strobe with combinational read data. It runs in one clock domain with an active-low reset.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the block is locked and the lock register reads 1. The control register reads 0, `irq` and `wdt_rst` are 0, interrupt status reads 0, and the reload register reads 0xFFFFFFFF.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, after which the lock register reads 0. Writing any other value to 0xC00 locks it again, after which it reads 1.
- R3: While the block is locked, writes to the reload register (0x000), the control register (0x008) and the clear register (0x00C) have no effect. Reads still return current state.
- R4: In the control register, bit 0 enables counting and the interrupt output, and bit 1 enables the reset output. Bits 31:2 always read 0.
- R5: When bit 0 goes from 0 to 1, the counter first loads the reload value and then decrements by one each clock. The current count reads at offset 0x004.
- R6: When the counter is at zero while enabled, the block sets the pending interrupt and reloads the counter. With reload value L, `irq` first reads 1 after L+2 clock edges, counted from the edge that wrote bit 0.
- R7: A write to 0x00C with bit 0 set clears the pending interrupt and reloads the counter. A write to 0x00C with bit 0 clear has no effect.
- R8: An expiry while the interrupt is still pending asserts `wdt_rst` if control bit 1 is set. This first happens 2L+3 edges after the enabling write. With bit 1 clear, `wdt_rst` stays 0.
- R9: Once asserted, `wdt_rst` stays 1 until `rst_n` is asserted, whatever is written to the block.
- R10: Clearing bit 0 freezes the count and keeps the reload value. It also masks `irq`, while bit 0 of the status register (0x014) still shows the raw pending flag.
- R11: The reload register accepts any 32-bit value, and the counter starts counting down from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase; a write takes effect on the edge where psel, penable and pwrite are all high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, combinational from paddr |
| irq | output | 1 | Pending interrupt, masked by the enable bit |
| wdt_rst | output | 1 | Sticky system reset request |

## Verification
The hardest situation to reach is the second-stage escalation. It needs two complete timeout periods with no service write in between, and the reset path enabled. The bench reaches it by sweeping small reload values, and it counts edges from the enabling write to the first `irq` and to the first `wdt_rst`. It compares those counts with L+2 and 2L+3. Other sequences hold back the escalation through the reset-enable bit, a missing key, or a steady series of service writes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned OFS_W = 12;
  localparam logic [OFS_W-1:0] OFS_RELOAD = 12'h000;
  localparam logic [OFS_W-1:0] OFS_COUNT  = 12'h004;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 12'h008;
  localparam logic [OFS_W-1:0] OFS_CLEAR  = 12'h00C;
  localparam logic [OFS_W-1:0] OFS_STAT   = 12'h014;
  localparam logic [OFS_W-1:0] OFS_LOCK   = 12'hC00;

  typedef struct packed {
    logic rst_en;
    logic run_en;
  } ctrl_t;
endpackage

// File: rtl/wdog_regif.sv
module wdog_regif #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'h1ACCE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] reload_q,
  output wdog_pkg::ctrl_t   ctrl_q,
  output logic              lock_q,
  output logic              clr_pulse
);
  import wdog_pkg::*;

  logic open_wr;
  assign open_wr = wr_stb && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b1;
      reload_q <= '1;
      ctrl_q   <= '0;
    end else begin
      if (wr_stb && waddr == ADDR_W'(OFS_LOCK))
        lock_q <= (wdata != KEY);
      if (open_wr && waddr == ADDR_W'(OFS_RELOAD))
        reload_q <= wdata;
      if (open_wr && waddr == ADDR_W'(OFS_CTRL)) begin
        ctrl_q.run_en <= wdata[0];
        ctrl_q.rst_en <= wdata[1];
      end
    end
  end

  assign clr_pulse = open_wr && waddr == ADDR_W'(OFS_CLEAR) && wdata[0];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic run_d;
  logic start;

  assign start  = run && !run_d;
  assign expire = run && run_d && !reload && count == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_d <= 1'b0;
      count <= '0;
    end else begin
      run_d <= run;
      if (reload || start)
        count <= reload_val;
      else if (run)
        count <= (count == '0) ? reload_val : count - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clear,
  input  logic rst_en,
  output logic pend,
  output logic sys_rst
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      sys_rst <= 1'b0;
    end else begin
      if (clear)
        pend <= 1'b0;
      else if (expire)
        pend <= 1'b1;
      if (expire && pend && rst_en)
        sys_rst <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'h1ACCE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq,
  output logic              wdt_rst
);
  import wdog_pkg::*;

  logic              wr_stb;
  logic [DATA_W-1:0] reload_q;
  ctrl_t             ctrl_q;
  logic              lock_q;
  logic              clr_pulse;
  logic [DATA_W-1:0] count;
  logic              expire;
  logic              pend_q;

  assign wr_stb = psel && penable && pwrite;

  wdog_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .waddr(paddr), .wdata(pwdata),
    .reload_q(reload_q), .ctrl_q(ctrl_q), .lock_q(lock_q), .clr_pulse(clr_pulse)
  );

  wdog_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run_en), .reload(clr_pulse),
    .reload_val(reload_q), .count(count), .expire(expire)
  );

  wdog_escalate u_esc (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clear(clr_pulse),
    .rst_en(ctrl_q.rst_en), .pend(pend_q), .sys_rst(wdt_rst)
  );

  assign irq = pend_q && ctrl_q.run_en;

  always_comb begin
    prdata = '0;
    unique case (paddr)
      ADDR_W'(OFS_RELOAD): prdata = reload_q;
      ADDR_W'(OFS_COUNT):  prdata = count;
      ADDR_W'(OFS_CTRL):   prdata = DATA_W'({ctrl_q.rst_en, ctrl_q.run_en});
      ADDR_W'(OFS_STAT):   prdata = DATA_W'(pend_q);
      ADDR_W'(OFS_LOCK):   prdata = DATA_W'(lock_q);
      default:             prdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              irq,
  input logic              wdt_rst,
  input logic              lock_q,
  input logic [DATA_W-1:0] reload_q,
  input logic              pend_q,
  input logic              run_en
);
  logic wr;
  assign wr = psel && penable && pwrite;

  // R9
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> wdt_rst);

  // R8
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $past(pend_q));

  // R3
  locked_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && lock_q && paddr == ADDR_W'(12'h000)) |=> $stable(reload_q));

  // R4
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paddr == ADDR_W'(12'h008)) |-> (prdata[DATA_W-1:2] == '0));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> run_en);

  // R7
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !lock_q && paddr == ADDR_W'(12'h00C) && pwdata[0]) |=> !pend_q);
endmodule

bind wdog_twostage wdog_twostage_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq), .wdt_rst(wdt_rst),
  .lock_q(lock_q), .reload_q(reload_q), .pend_q(pend_q), .run_en(ctrl_q.run_en)
);

// File: tb/wdog_twostage_test.sv
module wdog_twostage_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq, wdt_rst;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_twostage uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq), .wdt_rst(wdt_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    paddr = a;
    #1;
    d = prdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, v2;
    int first_irq, first_rst;

    do_reset();
    // R1 reset state
    rd(12'hC00, v); check("R1 lock", v, 1);
    rd(12'h008, v); check("R1 ctrl", v, 0);
    rd(12'h000, v); check("R1 reload", v, 32'hFFFFFFFF);
    rd(12'h014, v); check("R1 status", v, 0);
    check("R1 irq", irq, 0);
    check("R1 wdt_rst", wdt_rst, 0);

    // R3 locked writes ignored
    wr(12'h000, 5);
    wr(12'h008, 3);
    rd(12'h000, v); check("R3 reload locked", v, 32'hFFFFFFFF);
    rd(12'h008, v); check("R3 ctrl locked", v, 0);

    // R2 key unlock and relock
    wr(12'hC00, KEY);
    rd(12'hC00, v); check("R2 unlocked", v, 0);
    wr(12'hC00, 32'h0);
    rd(12'hC00, v); check("R2 relocked", v, 1);
    wr(12'h000, 7);
    rd(12'h000, v); check("R3 reload after relock", v, 32'hFFFFFFFF);

    // R4 reserved bits
    wr(12'hC00, KEY);
    wr(12'h008, 32'hFFFFFFFC);
    rd(12'h008, v); check("R4 reserved", v, 0);
    wr(12'h008, 32'h2);
    rd(12'h008, v); check("R4 rst_en bit", v, 2);
    wr(12'h008, 0);

    // R11 full-range load and R5 decrement
    wr(12'h000, 32'hFFFFFFFF);
    rd(12'h000, v); check("R11 max reload", v, 32'hFFFFFFFF);
    wr(12'h000, 32'hFFFFFFFE);
    wr(12'h008, 1);
    wait_cyc(1);
    rd(12'h004, v); check("R5 start value", v, 32'hFFFFFFFE);
    wait_cyc(2);
    rd(12'h004, v); check("R11 R5 decrement", v, 32'hFFFFFFFC);

    // R6 R8 timing sweep with reset enabled
    for (int l = 0; l < 5; l++) begin
      do_reset();
      wr(12'hC00, KEY);
      wr(12'h000, l);
      wr(12'h008, 3);
      first_irq = -1; first_rst = -1;
      for (int n = 1; n <= 2*l + 6; n++) begin
        @(negedge clk);
        if (irq && first_irq < 0) first_irq = n;
        if (wdt_rst && first_rst < 0) first_rst = n;
      end
      check($sformatf("R6 first irq L=%0d", l), first_irq, l + 2);
      check($sformatf("R8 first rst L=%0d", l), first_rst, 2*l + 3);
    end

    // R9 reset is sticky
    wr(12'h00C, 1);
    wr(12'h008, 0);
    wr(12'hC00, 0);
    wait_cyc(3);
    check("R9 sticky", wdt_rst, 1);

    // R8 no reset when rst_en clear
    for (int l = 0; l < 3; l++) begin
      do_reset();
      wr(12'hC00, KEY);
      wr(12'h000, l);
      wr(12'h008, 1);
      wait_cyc(3*l + 8);
      check($sformatf("R8 no rst L=%0d", l), wdt_rst, 0);
      check($sformatf("R6 irq held L=%0d", l), irq, 1);
    end

    // R7 clear with bit0 clear is ignored, bit0 set clears
    wr(12'h00C, 32'h2);
    rd(12'h014, v); check("R7 clear bit0=0", v, 1);
    // R3 clear while locked ignored
    wr(12'hC00, 32'h5);
    wr(12'h00C, 1);
    rd(12'h014, v); check("R3 clear locked", v, 1);
    wr(12'hC00, KEY);
    wr(12'h00C, 1);
    rd(12'h014, v); check("R7 clear bit0=1", v, 0);
    check("R7 irq dropped", irq, 0);

    // R7 periodic service prevents escalation
    do_reset();
    wr(12'hC00, KEY);
    wr(12'h000, 6);
    wr(12'h008, 3);
    v2 = 0;
    for (int k = 0; k < 10; k++) begin
      wait_cyc(3);
      wr(12'h00C, 1);
      rd(12'h004, v);
      if (v != 6) v2 = v;
      if (irq || wdt_rst) v2 = 32'hDEAD;
    end
    check("R7 service reload", v2, 0);
    check("R7 no escalation", wdt_rst, 0);

    // R10 disable freezes count, masks irq
    wr(12'h000, 20);
    wait_cyc(5);
    wr(12'h008, 0);
    rd(12'h004, v);
    wait_cyc(3);
    rd(12'h004, v2);
    check("R10 frozen count", v2, v);
    rd(12'h000, v); check("R10 reload kept", v, 20);
    wr(12'h000, 2);
    wr(12'h008, 1);
    wait_cyc(10);
    wr(12'h008, 0);
    check("R10 irq masked", irq, 0);
    rd(12'h014, v); check("R10 raw status", v, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule